// File: doc/BRIEF.md
# Startup Integrity-Check Retry Sequencer

This block holds a device in its power-on phase while an external checker confirms that the configuration image is intact. It starts one check with a single-cycle start strobe. It then waits for the checker's done pulse and reads the pass/fail result on that pulse. After a failed check it starts the check again, up to a fixed number of retries.

A passing check ends the sequence and raises the ready signal. If every retry fails, the sequence still ends and ready is still raised, but a failure flag is also set. The number of failed checks and the failure flag are both visible in a single status word. Every result holds until the next reset. The checker's arithmetic is outside this block; only its done and pass lines enter it.

Top module: `crc_retry_seq`

## Requirements
- R1: While rst_ni is low, chk_start_o and pwr_ready_o are 0 and status_o is all zeros.
- R2: On the first rising edge after reset release, chk_start_o goes high, and it stays high for exactly one clock cycle.
- R3: chk_done_i is acted on only while a check is outstanding, meaning after the start strobe and before the result. A done pulse in the same cycle as the start strobe is ignored and changes neither the count nor ready.
- R4: A failed result while the count is below MAX_RETRY (default 8) adds one to the count. The next start strobe is high in the cycle right after the failing done pulse.
- R5: A passing result raises pwr_ready_o in the next cycle. The count then stays equal to the number of failed checks seen before the pass, and no further start strobe is issued.
- R6: A failed result while the count already equals MAX_RETRY sets the failure flag to 1 and raises pwr_ready_o. The count stays at MAX_RETRY. The flag is never 1 unless the count equals MAX_RETRY.
- R7: status_o layout: the count sits in the top CNT_W bits (bits 7:4 by default), bit 0 is the failure flag, and all bits between them read 0.
- R8: Once pwr_ready_o is high, it stays high and status_o stays unchanged until reset, whatever chk_done_i and chk_pass_i do.
- R9: chk_start_o is never high in a cycle where pwr_ready_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| chk_done_i | input | 1 | Checker finished; a one-cycle pulse |
| chk_pass_i | input | 1 | Checker result, valid together with chk_done_i |
| chk_start_o | output | 1 | One-cycle request to start a check |
| pwr_ready_o | output | 1 | Power-on sequence complete |
| status_o | output | STAT_W (8) | Failure count in the upper bits, failure flag in bit 0 |

## Verification
The start strobe appears one edge after reset release. Every result of a done pulse (count update, new start strobe, ready, flag) shows up at the first edge after the cycle in which the done pulse was driven. The bench drives inputs on the falling edge. It checks each effect at the next falling edge, that is, half a cycle after the edge that registers it, and it confirms the one-cycle strobe width at the falling edge after that. The bench sweeps the number of failures from zero up to one beyond the retry limit, with several checker latencies. It injects stray done pulses together with the start strobe and after ready, and checks at the ports that they have no effect.

// File: rtl/crc_seq_pkg.sv
package crc_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_LAUNCH = 2'd1,
    ST_WAIT   = 2'd2,
    ST_DONE   = 2'd3
  } seq_state_e;
endpackage

// File: rtl/crc_seq_ctrl.sv
module crc_seq_ctrl
  import crc_seq_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic done_i,
  input  logic pass_i,
  input  logic at_limit_i,
  output logic start_o,
  output logic ready_o,
  output logic fail_inc_o,
  output logic fail_last_o
);
  seq_state_e state_q, state_d;
  logic       eval;

  assign eval = (state_q == ST_WAIT) && done_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   state_d = ST_LAUNCH;
      ST_LAUNCH: state_d = ST_WAIT;
      ST_WAIT:   if (done_i) state_d = (pass_i || at_limit_i) ? ST_DONE : ST_LAUNCH;
      ST_DONE:   state_d = ST_DONE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign start_o     = (state_q == ST_LAUNCH);
  assign ready_o     = (state_q == ST_DONE);
  assign fail_inc_o  = eval && !pass_i && !at_limit_i;
  assign fail_last_o = eval && !pass_i && at_limit_i;

  p_start_one_cycle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o);
  p_no_start_when_ready_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> !start_o);
  p_ready_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> ready_o);
  p_retry_restarts_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_inc_o |=> start_o);
  p_launch_ignores_done_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !ready_o);
endmodule

// File: rtl/crc_seq_tally.sv
module crc_seq_tally #(
  parameter int unsigned MAX_RETRY = 8,
  parameter int unsigned CNT_W     = $clog2(MAX_RETRY + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             last_i,
  output logic [CNT_W-1:0] count_o,
  output logic             flag_o,
  output logic             at_limit_o
);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MAX_RETRY);

  logic [CNT_W-1:0] count_q;
  logic             flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= '0;
      flag_q  <= 1'b0;
    end else begin
      if (inc_i)  count_q <= count_q + 1'b1;
      if (last_i) flag_q  <= 1'b1;
    end
  end

  assign count_o    = count_q;
  assign flag_o     = flag_q;
  assign at_limit_o = (count_q == LIMIT);

  p_count_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= LIMIT);
  p_flag_only_at_limit_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_q |-> (count_q == LIMIT));
  p_inc_below_limit_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i |=> (count_q == $past(count_q) + 1'b1));
endmodule

// File: rtl/crc_seq_status.sv
module crc_seq_status #(
  parameter int unsigned CNT_W  = 4,
  parameter int unsigned STAT_W = 8
) (
  input  logic [CNT_W-1:0]  count_i,
  input  logic              flag_i,
  output logic [STAT_W-1:0] status_o
);
  localparam int unsigned CNT_LSB = STAT_W - CNT_W;

  assign status_o[STAT_W-1:CNT_LSB] = count_i;
  assign status_o[0]                = flag_i;

  for (genvar g = 1; g < CNT_LSB; g++) begin : g_rsvd
    assign status_o[g] = 1'b0;
  end

  initial begin
    a_layout_fits_r7: assert (STAT_W >= CNT_W + 1);
  end
endmodule

// File: rtl/crc_retry_seq.sv
module crc_retry_seq #(
  parameter int unsigned MAX_RETRY = 8,
  parameter int unsigned STAT_W    = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              chk_done_i,
  input  logic              chk_pass_i,
  output logic              chk_start_o,
  output logic              pwr_ready_o,
  output logic [STAT_W-1:0] status_o
);
  localparam int unsigned CNT_W = $clog2(MAX_RETRY + 1);

  logic             fail_inc, fail_last, at_limit, flag;
  logic [CNT_W-1:0] count;

  crc_seq_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .done_i      (chk_done_i),
    .pass_i      (chk_pass_i),
    .at_limit_i  (at_limit),
    .start_o     (chk_start_o),
    .ready_o     (pwr_ready_o),
    .fail_inc_o  (fail_inc),
    .fail_last_o (fail_last)
  );

  crc_seq_tally #(.MAX_RETRY(MAX_RETRY), .CNT_W(CNT_W)) u_tally (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .inc_i      (fail_inc),
    .last_i     (fail_last),
    .count_o    (count),
    .flag_o     (flag),
    .at_limit_o (at_limit)
  );

  crc_seq_status #(.CNT_W(CNT_W), .STAT_W(STAT_W)) u_status (
    .count_i  (count),
    .flag_i   (flag),
    .status_o (status_o)
  );

  p_status_frozen_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_ready_o |=> $stable(status_o));
  p_flag_needs_ready_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[0] |-> pwr_ready_o);
  p_count_frozen_waiting_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !chk_done_i |=> $stable(status_o));
endmodule

// File: tb/crc_retry_seq_test.sv
`timescale 1ns/1ps
module crc_retry_seq_test;
  localparam int MAX = 8;
  localparam int SW  = 8;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          chk_done_i = 1'b0;
  logic          chk_pass_i = 1'b0;
  logic          chk_start_o;
  logic          pwr_ready_o;
  logic [SW-1:0] status_o;

  int n_run = 0;
  int n_fail = 0;

  always #4 clk_i = ~clk_i;

  crc_retry_seq #(.MAX_RETRY(MAX), .STAT_W(SW)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .chk_done_i(chk_done_i), .chk_pass_i(chk_pass_i),
    .chk_start_o(chk_start_o), .pwr_ready_o(pwr_ready_o), .status_o(status_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [SW-1:0] pack(input int cnt, input bit flg);
    return SW'((cnt << 4) | int'(flg));
  endfunction

  // fails: number of failing checks before a pass (> MAX means all fail)
  task automatic run(input int fails, input int lat, input bit spur);
    int att;
    bit fin;
    chk_done_i = 0; chk_pass_i = 0; rst_ni = 0;
    repeat (2) @(negedge clk_i);
    check("R1 start", chk_start_o, 0);
    check("R1 ready", pwr_ready_o, 0);
    check("R1 status", status_o, 0);
    rst_ni = 1;
    @(negedge clk_i);
    check("R2 first strobe", chk_start_o, 1);
    att = 0; fin = 0;
    while (!fin) begin
      if (spur) begin chk_done_i = 1; chk_pass_i = 1; end
      @(negedge clk_i);
      chk_done_i = 0; chk_pass_i = 0;
      check("R2 strobe width", chk_start_o, 0);
      if (spur) begin
        check("R3 ignored ready", pwr_ready_o, 0);
        check("R3 ignored count", status_o, pack(att, 0));
      end
      repeat (lat) @(negedge clk_i);
      chk_done_i = 1;
      chk_pass_i = (att == fails);
      @(negedge clk_i);
      chk_done_i = 0; chk_pass_i = 0;
      if (att == fails) begin
        check("R5 ready", pwr_ready_o, 1);
        check("R5 count", status_o, pack(att, 0));
        check("R9 no strobe", chk_start_o, 0);
        fin = 1;
      end else if (att == MAX) begin
        check("R6 ready", pwr_ready_o, 1);
        check("R6 flag", status_o, pack(MAX, 1));
        check("R9 no strobe", chk_start_o, 0);
        fin = 1;
      end else begin
        att++;
        check("R4 count", status_o, pack(att, 0));
        check("R4 restrobe", chk_start_o, 1);
        check("R4 not ready", pwr_ready_o, 0);
      end
    end
    // R8: stray results after completion change nothing
    for (int k = 0; k < 4; k++) begin
      chk_done_i = 1; chk_pass_i = k[0];
      @(negedge clk_i);
      chk_done_i = 0;
      @(negedge clk_i);
      check("R8 ready hold", pwr_ready_o, 1);
      check("R8 status hold", status_o, (fails > MAX) ? pack(MAX, 1) : pack(fails, 0));
      check("R9 no strobe", chk_start_o, 0);
    end
    check("R7 reserved bits", status_o[3:1], 0);
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    for (int f = 0; f <= MAX + 1; f++) begin
      for (int l = 0; l < 3; l++) begin
        run(f, l, l == 1);
      end
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule